// File: doc/BRIEF.md
# Three-Input Bitwise Function Unit

This execution unit applies one freely chosen three-input Boolean function to every bit position of three XLEN-bit operands at once. The function is given per operation as an 8-bit truth table. One operand is the current content of the destination register, so the unit can merge, select or combine bits of the old destination with two other sources in a single step. The whole result then replaces the destination.

An operation is accepted on a cycle where `in_valid` is high. The result appears on the registered outputs one cycle later, together with a one-cycle `out_valid` pulse. When the record flag is set, the unit also updates a 4-bit condition field. Three of its bits classify the signed result as negative, positive or zero. The fourth bit copies the summary-overflow input. When the record flag is clear, the condition field keeps its previous value.

Top module: `tri_logic_unit`

## Requirements
- R1: For each bit position i, the unit forms index k = {old_dst[i], src_a[i], src_b[i]}, with old_dst as the most significant bit. Result bit i equals truth_tbl[k], where truth_tbl bit 0 is the least significant bit.
- R2: The result of an operation accepted at a clock edge (in_valid high) is presented on `result` after that edge and stays there until the next accepted operation. All XLEN bits are replaced.
- R3: `out_valid` is high for exactly the one cycle after each accepted operation and low otherwise.
- R4: On an operation with rec_en high, the condition bits are set from the result as follows:
  - cond[3] is 1 when the result MSB is 1.
  - cond[2] is 1 when the result is nonzero with MSB 0.
  - cond[1] is 1 when the result is zero.
  - Exactly one of cond[3:1] is set.
- R5: On an operation with rec_en high, cond[0] takes the value of `so_in` sampled with that operation.
- R6: On an operation with rec_en low, `cond` keeps its previous value while `result` is updated.
- R7: In cycles where in_valid is low, the operand, truth-table, record and overflow inputs are ignored, and `result` and `cond` hold.
- R8: While rst_n is low, `result`, `cond` and `out_valid` are all 0.
- R9: Truth table 0x00 yields all zeros and 0xFF yields all ones, for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| old_dst | input | XLEN | Current destination value (index MSB) |
| src_a | input | XLEN | First source (index middle bit) |
| src_b | input | XLEN | Second source (index LSB) |
| truth_tbl | input | 8 | Truth table of the function |
| rec_en | input | 1 | Record flag: update condition field |
| so_in | input | 1 | Summary-overflow value to copy |
| out_valid | output | 1 | Result valid pulse |
| result | output | XLEN | Registered result |
| cond | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The result update and the condition-field update occur in the same cycle whenever an operation carries the record flag. The bench issues back-to-back operations that alternate the record flag. At every recorded operation it checks that `cond` classifies the newly written `result` and not the previous one. At every unrecorded operation it checks that `cond` is unchanged while `result` moves. It also issues an operation with the flag set and a zero result directly after one with a negative result, to confirm that both outputs switch on the same edge.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
    localparam int TT_W   = 8;
    localparam int CC_W   = 4;
    localparam int CC_NEG = 3;
    localparam int CC_POS = 2;
    localparam int CC_ZER = 1;
    localparam int CC_SO  = 0;
    typedef logic [CC_W-1:0] cc_t;
endpackage

// File: rtl/tlu_lut_slice.sv
module tlu_lut_slice
    import tlu_pkg::*;
(
    input  logic            d_bit,
    input  logic            a_bit,
    input  logic            b_bit,
    input  logic [TT_W-1:0] tbl,
    output logic            y
);
    logic [2:0] sel;
    always_comb begin
        sel = {d_bit, a_bit, b_bit};
        y   = tbl[sel];
    end
endmodule

// File: rtl/tlu_cond_gen.sv
module tlu_cond_gen
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] res,
    input  logic            so,
    output cc_t             cc
);
    logic neg, zer;
    always_comb begin
        neg = res[XLEN-1];
        zer = (res == '0);
        cc          = '0;
        cc[CC_NEG]  = neg;
        cc[CC_ZER]  = zer;
        cc[CC_POS]  = ~neg & ~zer;
        cc[CC_SO]   = so;
    end
endmodule

// File: rtl/tri_logic_unit.sv
module tri_logic_unit
    import tlu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] old_dst,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [7:0]      truth_tbl,
    input  logic            rec_en,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic [3:0]      cond
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        cc_t             cc;
    } state_t;

    state_t          st_d, st_q;
    logic [XLEN-1:0] fn_out;
    cc_t             cc_new;

    for (genvar i = 0; i < XLEN; i++) begin : g_slice
        tlu_lut_slice u_slice (
            .d_bit (old_dst[i]),
            .a_bit (src_a[i]),
            .b_bit (src_b[i]),
            .tbl   (truth_tbl),
            .y     (fn_out[i])
        );
    end

    tlu_cond_gen #(.XLEN(XLEN)) u_cond (
        .res (fn_out),
        .so  (so_in),
        .cc  (cc_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = fn_out;
            if (rec_en) st_d.cc = cc_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign cond      = st_q.cc;

    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_cond_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && rec_en) |=> $stable(cond));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    assert_cond_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> ($countones(cond[3:1]) == 1));
    assert_cond_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> (cond[1] == (result == '0)));
    assert_cond_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> (cond[3] == result[XLEN-1]));
    assert_so_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> (cond[0] == $past(so_in)));
endmodule

// File: tb/tri_logic_unit_bench.sv
`timescale 1ns/1ps
module tri_logic_unit_bench;
    localparam int XLEN = 64;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [XLEN-1:0] old_dst = '0, src_a = '0, src_b = '0;
    logic [7:0]      truth_tbl = '0;
    logic            rec_en = 1'b0, so_in = 1'b0;
    logic            out_valid;
    logic [XLEN-1:0] result;
    logic [3:0]      cond;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tri_logic_unit #(.XLEN(XLEN)) u_tri_logic_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .old_dst(old_dst),
        .src_a(src_a), .src_b(src_b), .truth_tbl(truth_tbl), .rec_en(rec_en),
        .so_in(so_in), .out_valid(out_valid), .result(result), .cond(cond));

    function automatic logic [XLEN-1:0] ref_fn(logic [XLEN-1:0] d, a, b, logic [7:0] t);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) r[i] = t[{d[i], a[i], b[i]}];
        return r;
    endfunction

    function automatic logic [3:0] ref_cc(logic [XLEN-1:0] r, logic so);
        logic n, z;
        n = r[XLEN-1];
        z = (r == '0);
        return {n, ~n & ~z, z, so};
    endfunction

    task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, capture at posedge, sample at following negedge
    task automatic issue(logic [XLEN-1:0] d, a, b, logic [7:0] t, logic rec, logic so);
        @(negedge clk);
        in_valid = 1'b1; old_dst = d; src_a = a; src_b = b;
        truth_tbl = t; rec_en = rec; so_in = so;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [XLEN-1:0] rnd();
        return {$urandom, $urandom};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R8 result", result, '0);
        chk("R8 cond", 64'(cond), 64'h0);
        chk("R8 out_valid", 64'(out_valid), 64'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_const();
        logic [XLEN-1:0] d, a, b;
        d = rnd(); a = rnd(); b = rnd();
        issue(d, a, b, 8'h00, 1'b0, 1'b0);
        chk("R9 tbl 00", result, '0);
        chk("R3 out_valid pulse", 64'(out_valid), 64'h1);
        issue(d, a, b, 8'hFF, 1'b0, 1'b0);
        chk("R9 tbl FF", result, '1);
    endtask

    task automatic t_named();
        logic [XLEN-1:0] d, a, b;
        d = 64'hF0F0_F0F0_F0F0_F0F0; a = 64'hCCCC_CCCC_CCCC_CCCC; b = 64'hAAAA_AAAA_AAAA_AAAA;
        issue(d, a, b, 8'h96, 1'b0, 1'b0);
        chk("R1 xor3", result, d ^ a ^ b);
        issue(d, a, b, 8'hE8, 1'b0, 1'b0);
        chk("R1 majority", result, (d & a) | (d & b) | (a & b));
        issue(d, a, b, 8'hF0, 1'b0, 1'b0);
        chk("R1 old_dst is MSB", result, d);
        issue(d, a, b, 8'hAA, 1'b0, 1'b0);
        chk("R1 src_b is LSB", result, b);
    endtask

    task automatic t_random();
        for (int n = 0; n < 40; n++) begin
            logic [XLEN-1:0] d, a, b;
            logic [7:0] t;
            d = rnd(); a = rnd(); b = rnd(); t = 8'($urandom);
            issue(d, a, b, t, 1'b0, 1'b0);
            chk("R2 random result", result, ref_fn(d, a, b, t));
        end
    endtask

    task automatic t_record();
        logic [3:0] prev;
        // negative result, so=1
        issue('0, '0, '0, 8'hFF, 1'b1, 1'b1);
        chk("R4 cond negative", 64'(cond), 64'(ref_cc('1, 1'b1)));
        chk("R5 so copy", 64'(cond[0]), 64'h1);
        // zero result right after, so=0
        issue('0, '0, '0, 8'h00, 1'b1, 1'b0);
        chk("R4 cond zero", 64'(cond), 64'h2);
        // positive result
        issue(64'h1, '0, '0, 8'h10, 1'b1, 1'b0);
        chk("R4 result positive", result, 64'h1);
        chk("R4 cond positive", 64'(cond), 64'h4);
        prev = cond;
        // unrecorded op producing negative result
        issue('0, '0, '0, 8'hFF, 1'b0, 1'b1);
        chk("R6 result updates", result, '1);
        chk("R6 cond held", 64'(cond), 64'(prev));
    endtask

    task automatic t_idle();
        logic [XLEN-1:0] keep_r;
        logic [3:0] keep_c;
        issue(64'h8000_0000_0000_0001, '0, '0, 8'hF0, 1'b1, 1'b0);
        keep_r = result; keep_c = cond;
        @(negedge clk);
        old_dst = '0; src_a = '1; src_b = '1; truth_tbl = 8'h00; rec_en = 1'b1; so_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 result held", result, keep_r);
        chk("R7 cond held", 64'(cond), 64'(keep_c));
        chk("R3 out_valid low idle", 64'(out_valid), 64'h0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_const();
        t_named();
        t_random();
        t_record();
        t_idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule